// File: doc/BRIEF.md
# Frame Writeback Buffer Ring Manager

This block decides where a stream of written-back video lines is placed in memory. It holds a ring of frame buffers, four by default. Each buffer has a base address for the luma plane and a base address for the chroma plane. The pixel pipeline sends frame-start and frame-end strobes and a line-valid pulse for each finished line. From these the block produces the byte address of the current line in each plane, along with a write-permitted flag for each plane. Line addresses step by the programmed pitch, which is counted in 256-byte units. An optional fence blocks any line that would extend past the programmed buffer size.

A frame start claims a buffer. The block searches round-robin from the buffer after the last one completed and takes the first buffer that software has not locked. If every buffer is locked, the frame is dropped and an overrun is recorded. Lines are counted into slices of programmable length. Frame-end, slice-end and overrun events set sticky status bits, which are cleared by write-one-to-clear. Two interrupt lines are built from the status bits: one for software, which sees all three events, and one for a video encoder, which sees frame and slice events. The current buffer index and the line count are exported for debug.

Top module: `fwb_ring_mgr`

## Requirements
- R1: After reset the manager is idle: `frame_active`=0, `cur_buf`=0, `line_cnt`=0, `status`=0, and both interrupt lines are low.
- R2: With `en`=1, an accepted `frame_start` sets `frame_active` and claims a buffer, searching from a pointer. An accepted `frame_end` clears `frame_active` and moves the pointer to `cur_buf`+1, modulo the buffer count. With no locks, successive frames therefore use buffers 0,1,2,3,0.
- R3: The search skips any buffer whose bit in `lock_mask` is 1 when `frame_start` is seen. If all buffers are locked, no frame begins and status bit 2 (overrun) is set.
- R4: While a frame is active, both write-permitted outputs are low whenever the lock bit of `cur_buf` is 1, including a lock applied in the middle of a frame.
- R5: `line_cnt` is 0 after a frame starts and increments on each `line_valid` during an active frame. The luma address is the luma base of `cur_buf` plus `line_cnt`×`luma_pitch`×256. The chroma address follows the same rule with the chroma base and `chroma_pitch`.
- R6: `slice_lines` holds the number of lines per slice minus one. Status bit 1 (slice end) is set on every (`slice_lines`+1)-th line of a frame.
- R7: With `fence_en`=1, the write-permitted flag of a plane is low when (`line_cnt`+1)×pitch exceeds that plane's size, where size is counted in 256-byte units. With `fence_en`=0, size has no effect.
- R8: With `planar`=0 (packed mode), `chroma_wr_ok` is 0 and `chroma_addr` is 0, while the luma path keeps working.
- R9: Status bits are sticky. A 1 in `status_clr` clears the matching bit. An event in the same cycle as a clear leaves the bit set.
- R10: `sw_irq` is high when any status bit and its `sw_ie` bit are both 1 (bit 0 frame end, bit 1 slice end, bit 2 overrun). `enc_irq` is high when status bits 0 or 1 are matched by `enc_ie` bit 0 (frame) or bit 1 (slice).
- R11: While `en`=0 the manager is idle. Strobes are ignored, `cur_buf`, the search pointer and `line_cnt` return to 0, and status is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Manager enable |
| planar | input | 1 | 1: separate chroma plane; 0: packed, luma path only |
| fence_en | input | 1 | Block lines past the buffer size |
| lock_mask | input | NBUF | Per-buffer software lock |
| luma_base | input | NBUF×AW | Luma byte base address per buffer |
| chroma_base | input | NBUF×AW | Chroma byte base address per buffer |
| luma_pitch | input | PITCHW | Luma line pitch, 256-byte units |
| chroma_pitch | input | PITCHW | Chroma line pitch, 256-byte units |
| luma_size | input | SIZEW | Luma buffer size, 256-byte units |
| chroma_size | input | SIZEW | Chroma buffer size, 256-byte units |
| slice_lines | input | SLICEW | Lines per slice minus one |
| sw_ie | input | 3 | Software interrupt enables {overrun, slice, frame} |
| enc_ie | input | 2 | Encoder interrupt enables {slice, frame} |
| status_clr | input | 3 | Write-one-to-clear for status bits |
| frame_start | input | 1 | Frame start strobe |
| frame_end | input | 1 | Frame end strobe |
| line_valid | input | 1 | One line written at the current address |
| luma_addr | output | AW | Current luma line byte address |
| chroma_addr | output | AW | Current chroma line byte address |
| luma_wr_ok | output | 1 | Luma write permitted |
| chroma_wr_ok | output | 1 | Chroma write permitted |
| frame_active | output | 1 | A frame owns a buffer |
| cur_buf | output | IDXW | Current buffer index (debug) |
| line_cnt | output | LINEW | Lines written in this frame (debug) |
| status | output | 3 | Sticky status {overrun, slice, frame} |
| sw_irq | output | 1 | Software interrupt |
| enc_irq | output | 1 | Encoder interrupt |

## Verification
A wrong search pointer becomes visible on `cur_buf` one cycle after the next `frame_start`, and it stays wrong for a whole frame. A miscounted line shows up one cycle after `line_valid`, as a wrong luma or chroma address or a slice status bit that arrives early or late. A misjudged fence or lock changes a write-permitted flag combinationally on the same line. Lost or stuck status bits show on the interrupt lines in the cycle after the event or the clear.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
   localparam int unsigned ST_W     = 3;
   localparam int unsigned ST_FRAME = 0;
   localparam int unsigned ST_SLICE = 1;
   localparam int unsigned ST_OVR   = 2;
   localparam int unsigned NPLANE   = 2;
   localparam int unsigned PL_LUMA  = 0;
   localparam int unsigned PL_CHROMA = 1;
endpackage

// File: rtl/fwb_buf_select.sv
module fwb_buf_select #(
   parameter int unsigned NBUF = 4,
   localparam int unsigned IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic [IDXW-1:0] start_idx,
   input  logic [NBUF-1:0] lock_mask,
   output logic            found,
   output logic [IDXW-1:0] pick
);
   always_comb begin
      found = 1'b0;
      pick  = start_idx;
      for (int k = NBUF - 1; k >= 0; k--) begin
         logic [IDXW-1:0] cand;
         cand = start_idx + IDXW'(k);
         if (!lock_mask[cand]) begin
            found = 1'b1;
            pick  = cand;
         end
      end
   end
endmodule

// File: rtl/fwb_line_track.sv
module fwb_line_track #(
   parameter int unsigned LINEW  = 14,
   parameter int unsigned SLICEW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   input  logic [SLICEW-1:0] slice_lines,
   output logic [LINEW-1:0]  line_cnt,
   output logic              slice_evt
);
   logic [SLICEW-1:0] slice_q;

   assign slice_evt = adv && (slice_q == slice_lines);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         slice_q  <= '0;
      end else if (restart) begin
         line_cnt <= '0;
         slice_q  <= '0;
      end else if (adv) begin
         line_cnt <= line_cnt + 1'b1;
         slice_q  <= slice_evt ? '0 : slice_q + 1'b1;
      end
   end
endmodule

// File: rtl/fwb_addr_gen.sv
module fwb_addr_gen #(
   parameter int unsigned AW     = 40,
   parameter int unsigned PITCHW = 8,
   parameter int unsigned SIZEW  = 20,
   parameter int unsigned LINEW  = 14,
   parameter int unsigned UNIT_SH = 8,
   localparam int unsigned OFFW  = LINEW + PITCHW,
   localparam int unsigned CMPW  = ((OFFW + 1) > SIZEW) ? (OFFW + 1) : SIZEW
) (
   input  logic [AW-1:0]     base,
   input  logic [PITCHW-1:0] pitch,
   input  logic [SIZEW-1:0]  size,
   input  logic [LINEW-1:0]  line,
   input  logic              fence_en,
   input  logic              allow,
   output logic [AW-1:0]     addr,
   output logic              wr_ok
);
   logic [OFFW-1:0] offset;
   logic [CMPW-1:0] line_end;
   logic            in_fence;

   assign offset   = OFFW'(line) * OFFW'(pitch);
   assign line_end = CMPW'(offset) + CMPW'(pitch);
   assign in_fence = !fence_en || (line_end <= CMPW'(size));
   assign addr     = base + AW'({offset, {UNIT_SH{1'b0}}});
   assign wr_ok    = allow && in_fence;
endmodule

// File: rtl/fwb_irq_ctrl.sv
module fwb_irq_ctrl
   import fwb_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] evt,
   input  logic [ST_W-1:0] clr,
   input  logic [ST_W-1:0] sw_ie,
   input  logic [1:0]      enc_ie,
   output logic [ST_W-1:0] status,
   output logic            sw_irq,
   output logic            enc_irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | evt;
   end

   assign sw_irq  = |(status & sw_ie);
   assign enc_irq = |(status[ST_SLICE:ST_FRAME] & enc_ie);
endmodule

// File: rtl/fwb_ring_mgr.sv
module fwb_ring_mgr
   import fwb_pkg::*;
#(
   parameter int unsigned NBUF    = 4,
   parameter int unsigned AW      = 40,
   parameter int unsigned PITCHW  = 8,
   parameter int unsigned SIZEW   = 20,
   parameter int unsigned SLICEW  = 12,
   parameter int unsigned LINEW   = 14,
   parameter int unsigned UNIT_SH = 8,
   localparam int unsigned IDXW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      planar,
   input  logic                      fence_en,
   input  logic [NBUF-1:0]           lock_mask,
   input  logic [NBUF-1:0][AW-1:0]   luma_base,
   input  logic [NBUF-1:0][AW-1:0]   chroma_base,
   input  logic [PITCHW-1:0]         luma_pitch,
   input  logic [PITCHW-1:0]         chroma_pitch,
   input  logic [SIZEW-1:0]          luma_size,
   input  logic [SIZEW-1:0]          chroma_size,
   input  logic [SLICEW-1:0]         slice_lines,
   input  logic [2:0]                sw_ie,
   input  logic [1:0]                enc_ie,
   input  logic [2:0]                status_clr,
   input  logic                      frame_start,
   input  logic                      frame_end,
   input  logic                      line_valid,
   output logic [AW-1:0]             luma_addr,
   output logic [AW-1:0]             chroma_addr,
   output logic                      luma_wr_ok,
   output logic                      chroma_wr_ok,
   output logic                      frame_active,
   output logic [IDXW-1:0]           cur_buf,
   output logic [LINEW-1:0]          line_cnt,
   output logic [2:0]                status,
   output logic                      sw_irq,
   output logic                      enc_irq
);
   // elaboration checks
   if (NBUF < 2 || (NBUF & (NBUF - 1)) != 0)
      $error("fwb_ring_mgr: NBUF must be a power of two, at least 2");
   if (AW < LINEW + PITCHW + UNIT_SH)
      $error("fwb_ring_mgr: AW too narrow for the largest line offset");
   if (SLICEW > LINEW)
      $error("fwb_ring_mgr: slice counter wider than line counter");

   logic [IDXW-1:0] ptr_q;
   logic            found;
   logic [IDXW-1:0] pick;
   logic            start_ok, end_ok, claim;
   logic            slice_evt;
   logic            wr_allow;

   fwb_buf_select #(.NBUF(NBUF)) u_sel (
      .start_idx (ptr_q),
      .lock_mask (lock_mask),
      .found     (found),
      .pick      (pick)
   );

   assign start_ok = en && frame_start && !frame_active;
   assign end_ok   = en && frame_end && frame_active;
   assign claim    = start_ok && found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_active <= 1'b0;
         cur_buf      <= '0;
         ptr_q        <= '0;
      end else if (!en) begin
         frame_active <= 1'b0;
         cur_buf      <= '0;
         ptr_q        <= '0;
      end else if (claim) begin
         frame_active <= 1'b1;
         cur_buf      <= pick;
      end else if (end_ok) begin
         frame_active <= 1'b0;
         ptr_q        <= cur_buf + 1'b1;
      end
   end

   fwb_line_track #(.LINEW(LINEW), .SLICEW(SLICEW)) u_lines (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (claim || !en),
      .adv         (en && frame_active && line_valid),
      .slice_lines (slice_lines),
      .line_cnt    (line_cnt),
      .slice_evt   (slice_evt)
   );

   assign wr_allow = frame_active && !lock_mask[cur_buf];

   logic [NPLANE-1:0][AW-1:0]     pl_base;
   logic [NPLANE-1:0][PITCHW-1:0] pl_pitch;
   logic [NPLANE-1:0][SIZEW-1:0]  pl_size;
   logic [NPLANE-1:0]             pl_allow;
   logic [NPLANE-1:0][AW-1:0]     pl_addr;
   logic [NPLANE-1:0]             pl_ok;

   assign pl_base[PL_LUMA]    = luma_base[cur_buf];
   assign pl_base[PL_CHROMA]  = chroma_base[cur_buf];
   assign pl_pitch[PL_LUMA]   = luma_pitch;
   assign pl_pitch[PL_CHROMA] = chroma_pitch;
   assign pl_size[PL_LUMA]    = luma_size;
   assign pl_size[PL_CHROMA]  = chroma_size;
   assign pl_allow[PL_LUMA]   = wr_allow;
   assign pl_allow[PL_CHROMA] = wr_allow && planar;

   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      fwb_addr_gen #(
         .AW(AW), .PITCHW(PITCHW), .SIZEW(SIZEW),
         .LINEW(LINEW), .UNIT_SH(UNIT_SH)
      ) u_agen (
         .base     (pl_base[p]),
         .pitch    (pl_pitch[p]),
         .size     (pl_size[p]),
         .line     (line_cnt),
         .fence_en (fence_en),
         .allow    (pl_allow[p]),
         .addr     (pl_addr[p]),
         .wr_ok    (pl_ok[p])
      );
   end

   assign luma_addr    = pl_addr[PL_LUMA];
   assign luma_wr_ok   = pl_ok[PL_LUMA];
   assign chroma_addr  = planar ? pl_addr[PL_CHROMA] : '0;
   assign chroma_wr_ok = pl_ok[PL_CHROMA];

   logic [ST_W-1:0] evt;
   assign evt[ST_FRAME] = end_ok;
   assign evt[ST_SLICE] = slice_evt;
   assign evt[ST_OVR]   = start_ok && !found;

   fwb_irq_ctrl u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .clr     (status_clr),
      .sw_ie   (sw_ie),
      .enc_ie  (enc_ie),
      .status  (status),
      .sw_irq  (sw_irq),
      .enc_irq (enc_irq)
   );
endmodule

// File: rtl/fwb_ring_mgr_chk.sv
module fwb_ring_mgr_chk #(
   parameter int unsigned NBUF = 4,
   parameter int unsigned IDXW = 2,
   parameter int unsigned LINEW = 14
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            planar,
   input logic [NBUF-1:0] lock_mask,
   input logic [2:0]      sw_ie,
   input logic [1:0]      enc_ie,
   input logic [2:0]      status_clr,
   input logic            frame_start,
   input logic            frame_end,
   input logic            luma_wr_ok,
   input logic            chroma_wr_ok,
   input logic            frame_active,
   input logic [IDXW-1:0] cur_buf,
   input logic [LINEW-1:0] line_cnt,
   input logic [2:0]      status,
   input logic            sw_irq,
   input logic            enc_irq
);
   a_r1_idle_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !frame_active && status == 3'b000);

   a_r2_frame_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
      en && frame_end && frame_active |=> !frame_active && status[0]);

   a_r3_all_locked_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      en && frame_start && !frame_active && (&lock_mask) |=> !frame_active && status[2]);

   a_r4_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      lock_mask[cur_buf] |-> !luma_wr_ok && !chroma_wr_ok);

   a_r8_packed_no_chroma: assert property (@(posedge clk) disable iff (!rst_n)
      !planar |-> !chroma_wr_ok);

   a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] && !status_clr[1] |=> status[1]);

   a_r10_sw_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      sw_irq |-> (status & sw_ie) != 3'b000);

   a_r10_enc_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      enc_irq |-> (status[1:0] & enc_ie) != 2'b00);

   a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !frame_active && cur_buf == '0 && line_cnt == '0);
endmodule

bind fwb_ring_mgr fwb_ring_mgr_chk #(.NBUF(NBUF), .IDXW(IDXW), .LINEW(LINEW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .planar(planar), .lock_mask(lock_mask),
   .sw_ie(sw_ie), .enc_ie(enc_ie), .status_clr(status_clr),
   .frame_start(frame_start), .frame_end(frame_end),
   .luma_wr_ok(luma_wr_ok), .chroma_wr_ok(chroma_wr_ok),
   .frame_active(frame_active), .cur_buf(cur_buf), .line_cnt(line_cnt),
   .status(status), .sw_irq(sw_irq), .enc_irq(enc_irq)
);

// File: tb/tb_fwb_ring_mgr.sv
module tb_fwb_ring_mgr;
   localparam int NBUF = 4, AW = 40, PITCHW = 8, SIZEW = 20, SLICEW = 12, LINEW = 14;

   logic clk = 0, rst_n = 0, en = 0, planar = 1, fence_en = 0;
   logic [NBUF-1:0] lock_mask = '0;
   logic [NBUF-1:0][AW-1:0] luma_base, chroma_base;
   logic [PITCHW-1:0] luma_pitch = 8'd4, chroma_pitch = 8'd2;
   logic [SIZEW-1:0] luma_size = 20'd4000, chroma_size = 20'd4000;
   logic [SLICEW-1:0] slice_lines = 12'd1;
   logic [2:0] sw_ie = '0, status_clr = '0;
   logic [1:0] enc_ie = '0;
   logic frame_start = 0, frame_end = 0, line_valid = 0;
   logic [AW-1:0] luma_addr, chroma_addr;
   logic luma_wr_ok, chroma_wr_ok, frame_active, sw_irq, enc_irq;
   logic [1:0] cur_buf;
   logic [LINEW-1:0] line_cnt;
   logic [2:0] status;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   fwb_ring_mgr dut (.*);

   function automatic logic [AW-1:0] lb(int i);
      return 40'h10_0000_0000 + 40'(i) * 40'h100_0000;
   endfunction
   function automatic logic [AW-1:0] cb(int i);
      return 40'h20_0000_0000 + 40'(i) * 40'h100_0000;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic start_frame(); frame_start = 1; @(negedge clk); frame_start = 0; endtask
   task automatic end_frame();   frame_end = 1;   @(negedge clk); frame_end = 0;   endtask
   task automatic lines(int n);
      for (int i = 0; i < n; i++) begin line_valid = 1; @(negedge clk); line_valid = 0; end
   endtask
   task automatic clear_all(); status_clr = 3'b111; @(negedge clk); status_clr = 3'b000; endtask

   task automatic t_reset();
      chk("R1 active", frame_active, 0);
      chk("R1 cur_buf", cur_buf, 0);
      chk("R1 line_cnt", line_cnt, 0);
      chk("R1 status", status, 0);
      chk("R1 irqs", {sw_irq, enc_irq}, 0);
   endtask

   task automatic t_rotate();
      for (int k = 0; k < 5; k++) begin
         start_frame();
         chk("R2 buffer order", cur_buf, k % 4);
         chk("R2 active after start", frame_active, 1);
         end_frame();
         chk("R2 inactive after end", frame_active, 0);
         chk("R2 frame status", status[0], 1);
      end
      clear_all();
   endtask

   task automatic t_lines();
      slice_lines = 12'd1;
      sw_ie = 3'b010; enc_ie = 2'b00;
      start_frame();
      chk("R5 buffer after wrap", cur_buf, 1);
      chk("R5 line zero addr", luma_addr, lb(1));
      lines(1);
      chk("R5 line count", line_cnt, 1);
      chk("R5 luma addr", luma_addr, lb(1) + 40'(1 * 4 * 256));
      chk("R6 no slice yet", status[1], 0);
      lines(1);
      chk("R6 slice after 2 lines", status[1], 1);
      chk("R10 sw slice irq", sw_irq, 1);
      chk("R10 enc masked", enc_irq, 0);
      clear_all();
      lines(1);
      chk("R6 mid slice", status[1], 0);
      lines(1);
      chk("R6 second slice", status[1], 1);
      lines(1);
      chk("R5 luma addr 5", luma_addr, lb(1) + 40'(5 * 4 * 256));
      chk("R5 chroma addr 5", chroma_addr, cb(1) + 40'(5 * 2 * 256));
      end_frame();
      clear_all();
      sw_ie = 3'b000;
   endtask

   task automatic t_lock();
      en = 0; @(negedge clk);
      chk("R11 pointer reset", cur_buf, 0);
      en = 1;
      lock_mask = 4'b0001;
      start_frame();
      chk("R3 skip locked", cur_buf, 1);
      end_frame();
      lock_mask = 4'b0100;
      start_frame();
      chk("R3 skip locked 2", cur_buf, 3);
      end_frame();
      lock_mask = 4'b1111; sw_ie = 3'b100;
      start_frame();
      chk("R3 dropped", frame_active, 0);
      chk("R3 overrun", status[2], 1);
      chk("R10 overrun irq", sw_irq, 1);
      clear_all();
      lock_mask = '0; sw_ie = '0;
   endtask

   task automatic t_lock_mid();
      start_frame();
      chk("R2 next after drop", cur_buf, 0);
      chk("R4 writable", {luma_wr_ok, chroma_wr_ok}, 2'b11);
      lock_mask = 4'b0001; @(negedge clk);
      chk("R4 locked mid frame", {luma_wr_ok, chroma_wr_ok}, 2'b00);
      lock_mask = '0; @(negedge clk);
      end_frame(); clear_all();
   endtask

   task automatic t_fence();
      luma_size = 20'd10; fence_en = 1;
      start_frame();
      chk("R7 line0 in", luma_wr_ok, 1);
      lines(1);
      chk("R7 line1 in", luma_wr_ok, 1);
      lines(1);
      chk("R7 line2 fenced", luma_wr_ok, 0);
      chk("R7 chroma unaffected", chroma_wr_ok, 1);
      fence_en = 0; @(negedge clk);
      chk("R7 fence off", luma_wr_ok, 1);
      end_frame(); clear_all();
      luma_size = 20'd4000;
   endtask

   task automatic t_packed();
      planar = 0;
      start_frame();
      lines(1);
      chk("R8 chroma ok low", chroma_wr_ok, 0);
      chk("R8 chroma addr zero", chroma_addr, 0);
      chk("R8 luma works", luma_wr_ok, 1);
      end_frame(); clear_all();
      planar = 1;
   endtask

   task automatic t_irq();
      enc_ie = 2'b01; sw_ie = 3'b000;
      start_frame();
      frame_end = 1; status_clr = 3'b001; @(negedge clk);
      frame_end = 0; status_clr = 3'b000;
      chk("R9 set wins over clear", status[0], 1);
      chk("R10 enc frame irq", enc_irq, 1);
      chk("R10 sw masked", sw_irq, 0);
      @(negedge clk);
      chk("R9 sticky", status[0], 1);
      status_clr = 3'b001; @(negedge clk); status_clr = 3'b000;
      chk("R9 cleared", status[0], 0);
      chk("R10 enc drops", enc_irq, 0);
      enc_ie = 2'b00;
   endtask

   task automatic t_disable();
      start_frame(); end_frame();
      en = 0; @(negedge clk);
      start_frame();
      chk("R11 start ignored", frame_active, 0);
      lines(2);
      chk("R11 lines ignored", line_cnt, 0);
      chk("R11 status held", status[0], 1);
      en = 1; clear_all();
   endtask

   initial begin
      for (int i = 0; i < NBUF; i++) begin luma_base[i] = lb(i); chroma_base[i] = cb(i); end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1; @(negedge clk);
      t_reset();
      en = 1; @(negedge clk);
      t_rotate();
      t_lines();
      t_lock();
      t_lock_mid();
      t_fence();
      t_packed();
      t_irq();
      t_disable();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule